// File: doc/BRIEF.md
# Interrupt Pending, Mask and Mode Register Bank

This block holds the per-source state of a 26-source interrupt controller and drives the two request lines to the CPU: a normal request (IRQ) and a fast request (FIQ). Each source has a pending bit, a mask bit and a mode bit. There is also one global mask bit. Every request input is first registered and then edge-detected. A rising edge latches the source's pending bit whether or not the source is masked. Pending bits are read-only. Software clears them by writing ones to one of two service-clear addresses, one for IRQ-mode sources and one for FIQ-mode sources. A write to a service-clear address also marks the end of that service routine.

Two sources are built from several inputs. Four external lines share source 21, and a 4-bit sub-pending field records which of those lines fired. Software clears that field by writing ones. Two UART error lines are ORed into source 13. Arbitration between sources and vector generation are done elsewhere. This block only states which IRQ-mode or FIQ-mode sources are pending and unmasked.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and has no side effects. The port has no valid/ready handshake because it carries no data stream and never back-pressures.

Top module: `intc_regbank`

## Requirements
- R1: After reset, all pending bits and all sub-pending bits are 0, all mode bits are 0, all mask bits are 1, the global mask is 1, and `irq` and `fiq` are both 0.
- R2: A 0-to-1 change on a request input sets its pending bit at the second rising clock edge after the change. A request held high sets the bit only once, so after a clear the bit stays 0 until the input goes low and rises again.
- R3: A pending bit latches on its request edge even when its mask bit or the global mask is 1.
- R4: Writing address 4 (IRQ service clear) clears each pending bit that has a 1 in the write data and a mode bit of 0. Writing address 5 (FIQ service clear) does the same for bits whose mode bit is 1. Bits written with 0 are unchanged.
- R5: `irq` is 1 exactly when the global mask is 0 and some source is pending, unmasked and has mode bit 0.
- R6: `fiq` is 1 exactly when the global mask is 0 and some source is pending, unmasked and has mode bit 1.
- R7: A rising edge on any bit n of `ext_req` sets sub-pending bit n (address 6, bits 3:0) and pending bit 21. Writing 1s to address 6 clears sub-pending bits. `src_req[21]` has no effect.
- R8: A rising edge on either bit of `uerr_req` sets pending bit 13. `src_req[13]` has no effect.
- R9: If a request edge and a clear of the same pending or sub-pending bit fall on the same clock edge, the bit ends up 1.
- R10: Register map. Address 0 is pending (read-only; writes have no effect). Address 1 is mode. Address 2 is mask. Address 3 is the global mask in bit 0, with the upper bits reading 0. Addresses 4 and 5 read 0. Address 6 is sub-pending in bits 3:0, with the upper bits reading 0. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle while high |
| reg_wdata | input | 26 | Write data |
| reg_rdata | output | 26 | Read data for `reg_addr` |
| src_req | input | 26 | Per-source request lines (bits 13 and 21 unused) |
| ext_req | input | 4 | External request lines sharing source 21 |
| uerr_req | input | 2 | UART error lines sharing source 13 |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Single isolated pulses on one source show that edge latching works under each combination of mask, mode and global mask. A request held high across a clear shows that edges are detected, not levels. Pulses on the shared external and UART lines, together with pulses on the two overridden `src_req` bits, separate the combined sources from plain ones. A clear issued in the same cycle as the request edge, and service-clear writes with all ones, check set-over-clear priority and the mode-qualified clearing. Together these cases tell the IRQ path apart from the FIQ path.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_SRC  = 26;
  localparam int unsigned EXT_N    = 4;
  localparam int unsigned UERR_N   = 2;
  localparam int unsigned EXT_SRC  = 21;
  localparam int unsigned UERR_SRC = 13;
  localparam int unsigned AW       = 3;

  typedef enum logic [AW-1:0] {
    SEL_PEND = 3'd0,
    SEL_MODE = 3'd1,
    SEL_MASK = 3'd2,
    SEL_GMSK = 3'd3,
    SEL_ICLR = 3'd4,
    SEL_FCLR = 3'd5,
    SEL_XSUB = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] stage_q;
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      hist_q  <= '0;
    end else begin
      stage_q <= din;
      hist_q  <= stage_q;
    end
  end

  assign rise = stage_q & ~hist_q;
endmodule

// File: rtl/intc_w1c_bank.sv
module intc_w1c_bank #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_req_gen.sv
module intc_req_gen #(
  parameter int unsigned W = 1
) (
  input  logic [W-1:0] pend,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] mode,
  input  logic         gmask,
  output logic         irq,
  output logic         fiq
);
  logic [W-1:0] live;
  assign live = pend & ~mask;
  assign irq  = !gmask && |(live & ~mode);
  assign fiq  = !gmask && |(live & mode);
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC   = NUM_SRC,
  parameter int unsigned N_EXT   = EXT_N,
  parameter int unsigned N_UERR  = UERR_N,
  parameter int unsigned X_SRC   = EXT_SRC,
  parameter int unsigned U_SRC   = UERR_SRC,
  parameter int unsigned ADDR_W  = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  input  logic [N_SRC-1:0]  src_req,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_UERR-1:0] uerr_req,
  output logic              irq,
  output logic              fiq
);
  localparam logic [N_SRC-1:0] SHARED = (N_SRC'(1) << X_SRC) | (N_SRC'(1) << U_SRC);

  logic [N_SRC-1:0] raw_req;
  logic [N_SRC-1:0] src_rise;
  logic [N_EXT-1:0] ext_rise;
  logic [N_SRC-1:0] pend_set;
  logic [N_SRC-1:0] pend_clr;
  logic [N_SRC-1:0] pend_q;
  logic [N_EXT-1:0] sub_q;
  logic [N_EXT-1:0] sub_clr;
  logic [N_SRC-1:0] mode_q;
  logic [N_SRC-1:0] mask_q;
  logic             gmask_q;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr);

  // Combined UART error lines replace their slot; the external slot is driven separately.
  always_comb begin
    raw_req        = src_req & ~SHARED;
    raw_req[U_SRC] = |uerr_req;
  end

  intc_edge_sync #(.W(N_SRC)) u_src_edge (
    .clk(clk), .rst_n(rst_n), .din(raw_req), .rise(src_rise)
  );

  intc_edge_sync #(.W(N_EXT)) u_ext_edge (
    .clk(clk), .rst_n(rst_n), .din(ext_req), .rise(ext_rise)
  );

  always_comb begin
    pend_set        = src_rise;
    pend_set[X_SRC] = |ext_rise;
    pend_clr        = '0;
    if (reg_wr && sel == SEL_ICLR) pend_clr = reg_wdata & ~mode_q;
    if (reg_wr && sel == SEL_FCLR) pend_clr = reg_wdata & mode_q;
    sub_clr = (reg_wr && sel == SEL_XSUB) ? reg_wdata[N_EXT-1:0] : '0;
  end

  intc_w1c_bank #(.W(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(pend_set), .clr(pend_clr), .q(pend_q)
  );

  intc_w1c_bank #(.W(N_EXT)) u_sub (
    .clk(clk), .rst_n(rst_n), .set(ext_rise), .clr(sub_clr), .q(sub_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mask_q  <= '1;
      gmask_q <= 1'b1;
    end else if (reg_wr) begin
      case (sel)
        SEL_MODE: mode_q  <= reg_wdata;
        SEL_MASK: mask_q  <= reg_wdata;
        SEL_GMSK: gmask_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_PEND: reg_rdata = pend_q;
      SEL_MODE: reg_rdata = mode_q;
      SEL_MASK: reg_rdata = mask_q;
      SEL_GMSK: reg_rdata[0] = gmask_q;
      SEL_XSUB: reg_rdata[N_EXT-1:0] = sub_q;
      default:  reg_rdata = '0;
    endcase
  end

  intc_req_gen #(.W(N_SRC)) u_req (
    .pend(pend_q), .mask(mask_q), .mode(mode_q), .gmask(gmask_q),
    .irq(irq), .fiq(fiq)
  );
endmodule

// File: rtl/intc_regbank_chk.sv
module intc_regbank_chk #(
  parameter int unsigned N_SRC = 26,
  parameter int unsigned N_EXT = 4,
  parameter int unsigned X_SRC = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_addr,
  input logic             reg_wr,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_EXT-1:0] sub_q,
  input logic             gmask_q,
  input logic             irq,
  input logic             fiq
);
  // R1
  reset_clears_pend_chk: assert property (@(posedge clk) !rst_n |=> pend_q == '0);

  // R4
  no_clear_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd5)) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R5
  gmask_blocks_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |-> (!irq && !fiq));

  // R6
  no_request_without_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (!irq && !fiq));

  // R7
  sub_rise_sets_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sub_q & ~$past(sub_q)) != '0) |-> pend_q[X_SRC]);
endmodule

bind intc_regbank intc_regbank_chk #(.N_SRC(N_SRC), .N_EXT(N_EXT), .X_SRC(X_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .pend_q(pend_q), .sub_q(sub_q), .gmask_q(gmask_q), .irq(irq), .fiq(fiq)
);

// File: tb/intc_regbank_test.sv
module intc_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [25:0] reg_wdata = '0;
  logic [25:0] reg_rdata;
  logic [25:0] src_req = '0;
  logic [3:0]  ext_req = '0;
  logic [1:0]  uerr_req = '0;
  logic        irq, fiq;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  intc_regbank uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
    .ext_req(ext_req), .uerr_req(uerr_req), .irq(irq), .fiq(fiq)
  );

  // Behavioural reference state
  bit [25:0] m_pend = '0, m_mode = '0, m_mask = '1, m_s1 = '0, m_s2 = '0;
  bit [3:0]  m_sub = '0, m_e1 = '0, m_e2 = '0;
  bit        m_gm = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_mode = '0; m_mask = '1; m_gm = 1'b1; m_sub = '0;
      m_s1 = '0; m_s2 = '0; m_e1 = '0; m_e2 = '0;
    end else begin
      bit [25:0] set, clr, nraw;
      bit [3:0]  eset, eclr;
      set = m_s1 & ~m_s2;
      eset = m_e1 & ~m_e2;
      if (eset != 0) set[21] = 1'b1;
      clr = '0; eclr = '0;
      if (reg_wr && reg_addr == 3'd4) clr = reg_wdata & ~m_mode;
      if (reg_wr && reg_addr == 3'd5) clr = reg_wdata & m_mode;
      if (reg_wr && reg_addr == 3'd6) eclr = reg_wdata[3:0];
      m_pend = (m_pend & ~clr) | set;
      m_sub  = (m_sub & ~eclr) | eset;
      if (reg_wr && reg_addr == 3'd1) m_mode = reg_wdata;
      if (reg_wr && reg_addr == 3'd2) m_mask = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) m_gm = reg_wdata[0];
      nraw = src_req;
      nraw[21] = 1'b0;
      nraw[13] = uerr_req[0] | uerr_req[1];
      m_s2 = m_s1; m_s1 = nraw;
      m_e2 = m_e1; m_e1 = ext_req;
    end
  end

  function automatic bit [25:0] m_read(input bit [2:0] a);
    case (a)
      3'd0: return m_pend;
      3'd1: return m_mode;
      3'd2: return m_mask;
      3'd3: return {25'd0, m_gm};
      3'd6: return {22'd0, m_sub};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      bit [25:0] live;
      live = m_pend & ~m_mask;
      check("R5 irq vs model", irq, !m_gm && |(live & ~m_mode));
      check("R6 fiq vs model", fiq, !m_gm && |(live & m_mode));
      check("R10 rdata vs model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input bit [2:0] a, input bit [25:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit [2:0] a, output logic [25:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [25:0] v;
    idle(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    rd(3'd0, v); check("R1 pend", v, 26'h0);
    rd(3'd1, v); check("R1 mode", v, 26'h0);
    rd(3'd2, v); check("R1 mask", v, 26'h3FFFFFF);
    rd(3'd3, v); check("R1 gmask", v, 26'h1);
    rd(3'd6, v); check("R1 sub", v, 26'h0);
    check("R1 irq", irq, 1'b0);
    check("R1 fiq", fiq, 1'b0);
    @(negedge clk);

    // R3 masked source latches
    src_req[10] = 1'b1; idle(3); src_req[10] = 1'b0;
    rd(3'd0, v); check("R3 masked pend", v, 26'h400);
    check("R3 masked irq", irq, 1'b0);
    @(negedge clk);

    // R2 timing: bit appears after second edge
    wr(3'd2, ~26'h408);
    src_req[3] = 1'b1;
    @(negedge clk); rd(3'd0, v); check("R2 not yet set", v[3], 1'b0);
    @(negedge clk); rd(3'd0, v); check("R2 set after two edges", v[3], 1'b1);
    check("R3 gmask holds irq low", irq, 1'b0);
    wr(3'd3, 26'h0);
    check("R5 irq asserted", irq, 1'b1);

    // R2 level held: clear and stay clear
    wr(3'd4, 26'h8);
    idle(3); rd(3'd0, v); check("R2 level no retrigger", v[3], 1'b0);
    src_req[3] = 1'b0;

    // R6 FIQ path
    wr(3'd1, 26'h80);
    wr(3'd2, ~26'h480);
    src_req[7] = 1'b1; idle(3); src_req[7] = 1'b0;
    check("R6 fiq asserted", fiq, 1'b1);
    // R4 IRQ clear leaves FIQ-mode bit
    wr(3'd4, '1);
    rd(3'd0, v); check("R4 irq clear keeps fiq bit", v, 26'h80);
    wr(3'd5, '1);
    rd(3'd0, v); check("R4 fiq clear", v, 26'h0);
    check("R6 fiq dropped", fiq, 1'b0);

    // R7 external lines; src_req[21] ignored
    src_req[21] = 1'b1; idle(3); src_req[21] = 1'b0;
    rd(3'd0, v); check("R7 src21 ignored", v[21], 1'b0);
    ext_req[2] = 1'b1; idle(3); ext_req[2] = 1'b0;
    rd(3'd6, v); check("R7 sub bit", v, 26'h4);
    rd(3'd0, v); check("R7 shared pend", v[21], 1'b1);
    wr(3'd6, 26'h4);
    rd(3'd6, v); check("R7 sub cleared", v, 26'h0);
    wr(3'd4, 26'h200000);

    // R8 UART error pair; src_req[13] ignored
    src_req[13] = 1'b1; idle(3); src_req[13] = 1'b0;
    rd(3'd0, v); check("R8 src13 ignored", v[13], 1'b0);
    uerr_req[1] = 1'b1; idle(3); uerr_req[1] = 1'b0;
    rd(3'd0, v); check("R8 uart pend", v[13], 1'b1);
    wr(3'd4, 26'h2000);

    // R9 set wins over same-cycle clear
    src_req[5] = 1'b1;
    @(negedge clk);
    wr(3'd4, 26'h20);
    rd(3'd0, v); check("R9 set beats clear", v[5], 1'b1);
    src_req[5] = 1'b0;
    ext_req[1] = 1'b1;
    @(negedge clk);
    wr(3'd6, 26'h2);
    rd(3'd6, v); check("R9 sub set beats clear", v, 26'h2);
    ext_req[1] = 1'b0;

    // R10 pending read-only, clear addresses read zero
    wr(3'd0, 26'h0);
    rd(3'd0, v); check("R10 pend write ignored", v[5], 1'b1);
    rd(3'd4, v); check("R10 iclr reads 0", v, 26'h0);
    rd(3'd5, v); check("R10 fclr reads 0", v, 26'h0);
    rd(3'd7, v); check("R10 addr7 reads 0", v, 26'h0);
    idle(4);
    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule